// File: doc/BRIEF.md
# Privileged Processor Status Word Unit

This block keeps a 16-bit processor status word together with two stack pointers, one for user code and one for supervisor code. The low byte of the word holds the condition flags. Any code may change this byte, either through per-flag updates from the arithmetic unit or through an explicit byte write. The high byte holds the trace bit, the supervisor bit and a three-bit interrupt mask. Only supervisor code may change it, and only through a full-word write. An attempt from user mode is dropped and answered with a one-cycle violation pulse.

An exception-entry strobe first copies the current word into a saved-status register and then forces supervisor mode. The active stack pointer output follows the supervisor bit. A stack-pointer write always lands in the pointer that is active at that clock edge, so the pointer of the other mode is kept unchanged across mode changes. The extend flag has its own update enable, separate from carry. This lets multiword arithmetic chains keep the extend flag while other instructions change carry.

Top module: `status_word_unit`

## Requirements
- R1: After reset the status word is 16'h2700 (supervisor, interrupt mask 7). Both stack pointers are zero, the saved status is zero and the violation pulse is low.
- R2: Bit layout of the status word: carry bit 0, overflow bit 1, zero bit 2, negative bit 3, extend bit 4, interrupt mask bits 10..8, supervisor bit 13, trace bit 15. Every other bit always reads zero (implemented mask 16'hA71F).
- R3: Each of the five flags has its own update enable (enable and value bit i map to status bit i). Flags whose enable is low keep their value, so extend changes independently of carry.
- R4: A condition-byte write loads status bits 4..0 from data bits 4..0 in either mode and leaves the high byte unchanged.
- R5: A full-word write in supervisor mode loads the data ANDed with 16'hA71F on the next edge.
- R6: A full-word write in user mode leaves the whole status word unchanged. The violation output is then high for exactly the following cycle. The violation output is low in all other cycles.
- R7: Within one cycle, priority runs from a full-word write (accepted or refused), to a condition-byte write, to arithmetic flag updates. Lower-priority requests in the same cycle are ignored.
- R8: Exception entry copies the current word to the saved-status output, sets the supervisor bit and keeps all other bits. Any word, byte or flag request in the same cycle is ignored and no violation is raised.
- R9: The active stack pointer output shows the supervisor pointer when the supervisor bit is 1 and the user pointer otherwise. A stack-pointer write goes to the pointer selected at that edge, and the other pointer is unchanged.
- R10: Clearing the supervisor bit by a word write switches the output to the user pointer. A later exception entry switches it back to the untouched supervisor pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flag_we | input | 5 | Per-flag update enables from the arithmetic unit |
| flag_val | input | 5 | Per-flag new values |
| ccr_we | input | 1 | Condition-byte write strobe |
| ccr_wdata | input | 8 | Condition-byte write data |
| word_we | input | 1 | Full-word write strobe |
| word_wdata | input | 16 | Full-word write data |
| exc_entry | input | 1 | Exception-entry strobe |
| sp_we | input | 1 | Write strobe for the active stack pointer |
| sp_wdata | input | SP_W | Stack-pointer write data |
| status | output | 16 | Current status word |
| supervisor | output | 1 | Current privilege mode (1 = supervisor) |
| active_sp | output | SP_W | Stack pointer selected by the mode |
| saved_status | output | 16 | Status word captured at the last exception entry |
| priv_fault | output | 1 | One-cycle privilege-violation pulse |

## Verification
The properties assume that every strobe is low while reset is held and that all inputs carry known values at each edge. Without this, history-based checks would read indeterminate values in the first cycle after reset. The stimulus starts with every input at zero during reset and changes inputs only just after a rising edge. Each request is therefore held stable for one full cycle and then returned to zero.

// File: rtl/psw_pkg.sv
package psw_pkg;
    localparam int SR_W      = 16;
    localparam int NFLAGS    = 5;
    localparam int IPL_LO    = 8;
    localparam int IPL_W     = 3;
    localparam int SUP_BIT   = 13;
    localparam int TRACE_BIT = 15;

    localparam logic [SR_W-1:0] FLAG_FIELD = SR_W'((1 << NFLAGS) - 1);
    localparam logic [SR_W-1:0] IPL_FIELD  = SR_W'(((1 << IPL_W) - 1) << IPL_LO);
    localparam logic [SR_W-1:0] SR_MASK    = SR_W'(1 << TRACE_BIT) | SR_W'(1 << SUP_BIT)
                                           | IPL_FIELD | FLAG_FIELD;
    localparam logic [SR_W-1:0] SR_RESET   = SR_W'(1 << SUP_BIT) | IPL_FIELD;

    typedef enum int {
        FLG_CARRY = 0,
        FLG_OVFL  = 1,
        FLG_ZERO  = 2,
        FLG_NEG   = 3,
        FLG_EXT   = 4
    } flag_idx_e;
endpackage

// File: rtl/ccr_merge.sv
module ccr_merge #(
    parameter int NF = 5
) (
    input  logic [NF-1:0] cur,
    input  logic [NF-1:0] alu_we,
    input  logic [NF-1:0] alu_val,
    input  logic          byte_we,
    input  logic [NF-1:0] byte_val,
    output logic [NF-1:0] nxt
);
    // Each flag is resolved on its own; extend has no tie to carry.
    for (genvar i = 0; i < NF; i++) begin : g_flag
        always_comb begin
            if (byte_we)
                nxt[i] = byte_val[i];
            else if (alu_we[i])
                nxt[i] = alu_val[i];
            else
                nxt[i] = cur[i];
        end
    end
endmodule

// File: rtl/priv_gate.sv
module priv_gate (
    input  logic word_we,
    input  logic sup_mode,
    input  logic exc_entry,
    output logic accept,
    output logic violate
);
    always_comb begin
        accept  = word_we &  sup_mode & ~exc_entry;
        violate = word_we & ~sup_mode & ~exc_entry;
    end
endmodule

// File: rtl/sp_bank.sv
module sp_bank #(
    parameter int W = 32
) (
    input  logic         sel_sup,
    input  logic         we,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] usp_q,
    input  logic [W-1:0] ssp_q,
    output logic [W-1:0] usp_d,
    output logic [W-1:0] ssp_d,
    output logic [W-1:0] active
);
    always_comb begin
        usp_d  = usp_q;
        ssp_d  = ssp_q;
        if (we) begin
            if (sel_sup) ssp_d = wdata;
            else         usp_d = wdata;
        end
        active = sel_sup ? ssp_q : usp_q;
    end
endmodule

// File: rtl/status_word_unit.sv
module status_word_unit
    import psw_pkg::*;
#(
    parameter int SP_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NFLAGS-1:0] flag_we,
    input  logic [NFLAGS-1:0] flag_val,
    input  logic              ccr_we,
    input  logic [7:0]        ccr_wdata,
    input  logic              word_we,
    input  logic [SR_W-1:0]   word_wdata,
    input  logic              exc_entry,
    input  logic              sp_we,
    input  logic [SP_W-1:0]   sp_wdata,
    output logic [SR_W-1:0]   status,
    output logic              supervisor,
    output logic [SP_W-1:0]   active_sp,
    output logic [SR_W-1:0]   saved_status,
    output logic              priv_fault
);
    typedef struct packed {
        logic [SR_W-1:0] sr;
        logic [SP_W-1:0] usp;
        logic [SP_W-1:0] ssp;
        logic [SR_W-1:0] saved;
        logic            fault;
    } unit_state_t;

    unit_state_t st_q, st_d;

    logic [NFLAGS-1:0] flags_nxt;
    logic [NFLAGS-1:0] alu_en;
    logic              byte_en;
    logic              word_ok;
    logic              word_bad;
    logic [SP_W-1:0]   usp_nxt;
    logic [SP_W-1:0]   ssp_nxt;
    logic [SP_W-1:0]   sp_sel;

    // A full-word request, granted or refused, suppresses lower requests.
    always_comb begin
        byte_en = ccr_we & ~word_we;
        alu_en  = flag_we & {NFLAGS{~word_we}};
    end

    ccr_merge #(.NF(NFLAGS)) u_ccr (
        .cur      (st_q.sr[NFLAGS-1:0]),
        .alu_we   (alu_en),
        .alu_val  (flag_val),
        .byte_we  (byte_en),
        .byte_val (ccr_wdata[NFLAGS-1:0]),
        .nxt      (flags_nxt)
    );

    priv_gate u_gate (
        .word_we   (word_we),
        .sup_mode  (st_q.sr[SUP_BIT]),
        .exc_entry (exc_entry),
        .accept    (word_ok),
        .violate   (word_bad)
    );

    sp_bank #(.W(SP_W)) u_sp (
        .sel_sup (st_q.sr[SUP_BIT]),
        .we      (sp_we),
        .wdata   (sp_wdata),
        .usp_q   (st_q.usp),
        .ssp_q   (st_q.ssp),
        .usp_d   (usp_nxt),
        .ssp_d   (ssp_nxt),
        .active  (sp_sel)
    );

    always_comb begin
        st_d       = st_q;
        st_d.fault = 1'b0;
        st_d.usp   = usp_nxt;
        st_d.ssp   = ssp_nxt;
        if (exc_entry) begin
            st_d.saved        = st_q.sr;
            st_d.sr[SUP_BIT]  = 1'b1;
        end else if (word_ok) begin
            st_d.sr = word_wdata & SR_MASK;
        end else if (word_bad) begin
            st_d.fault = 1'b1;
        end else begin
            st_d.sr[NFLAGS-1:0] = flags_nxt;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.sr    <= SR_RESET;
            st_q.usp   <= '0;
            st_q.ssp   <= '0;
            st_q.saved <= '0;
            st_q.fault <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        status       = st_q.sr;
        supervisor   = st_q.sr[SUP_BIT];
        active_sp    = sp_sel;
        saved_status = st_q.saved;
        priv_fault   = st_q.fault;
    end
endmodule

// File: rtl/status_word_checker.sv
module status_word_checker
    import psw_pkg::*;
#(
    parameter int SP_W = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            ccr_we,
    input logic            word_we,
    input logic            exc_entry,
    input logic            sp_we,
    input logic [SR_W-1:0] status,
    input logic            supervisor,
    input logic [SP_W-1:0] active_sp,
    input logic [SR_W-1:0] saved_status,
    input logic            priv_fault
);
    assert_unused_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (status & ~SR_MASK) == '0);

    assert_fault_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
        priv_fault |-> ($past(word_we) && !$past(supervisor) && !$past(exc_entry)));

    assert_refused_keeps_word_R6: assert property (@(posedge clk) disable iff (!rst_n)
        priv_fault |-> status == $past(status));

    assert_user_cannot_raise_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(supervisor) && !$past(exc_entry)) |-> !supervisor);

    assert_entry_saves_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(exc_entry) |-> (supervisor && saved_status == $past(status) && !priv_fault));

    assert_sp_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(sp_we) && $past(supervisor) == supervisor) |-> $stable(active_sp));

    assert_saved_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(exc_entry) |-> $stable(saved_status));
endmodule

bind status_word_unit status_word_checker #(.SP_W(SP_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .ccr_we       (ccr_we),
    .word_we      (word_we),
    .exc_entry    (exc_entry),
    .sp_we        (sp_we),
    .status       (status),
    .supervisor   (supervisor),
    .active_sp    (active_sp),
    .saved_status (saved_status),
    .priv_fault   (priv_fault)
);

// File: tb/sim_status_word_unit.sv
module sim_status_word_unit;
    localparam int SPW = 32;
    localparam logic [15:0] MASK = 16'hA71F;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [4:0]      flag_we = '0;
    logic [4:0]      flag_val = '0;
    logic            ccr_we = 1'b0;
    logic [7:0]      ccr_wdata = '0;
    logic            word_we = 1'b0;
    logic [15:0]     word_wdata = '0;
    logic            exc_entry = 1'b0;
    logic            sp_we = 1'b0;
    logic [SPW-1:0]  sp_wdata = '0;
    logic [15:0]     status;
    logic            supervisor;
    logic [SPW-1:0]  active_sp;
    logic [15:0]     saved_status;
    logic            priv_fault;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    status_word_unit #(.SP_W(SPW)) u0 (
        .clk(clk), .rst_n(rst_n), .flag_we(flag_we), .flag_val(flag_val),
        .ccr_we(ccr_we), .ccr_wdata(ccr_wdata), .word_we(word_we),
        .word_wdata(word_wdata), .exc_entry(exc_entry), .sp_we(sp_we),
        .sp_wdata(sp_wdata), .status(status), .supervisor(supervisor),
        .active_sp(active_sp), .saved_status(saved_status), .priv_fault(priv_fault)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Apply the currently driven inputs for one edge, sample 1 ns later, clear them.
    task automatic tick();
        @(posedge clk);
        #1;
        flag_we = '0; flag_val = '0; ccr_we = 0; ccr_wdata = '0;
        word_we = 0; word_wdata = '0; exc_entry = 0; sp_we = 0; sp_wdata = '0;
    endtask

    initial begin
        #1_500_000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] cur;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        // R1 reset state
        chk("R1 status", 32'(status), 32'h2700);
        chk("R1 sp", active_sp, 0);
        chk("R1 saved", 32'(saved_status), 0);
        chk("R1 fault", 32'(priv_fault), 0);

        // R3 / R4: sweep every enable and value pattern from varied base flags
        for (int we = 0; we < 32; we++) begin
            for (int v = 0; v < 32; v++) begin
                logic [4:0] base;
                base = 5'((we * 7 + v * 3) & 31);
                ccr_we = 1; ccr_wdata = {3'b101, base};
                tick();
                chk("R4 byte write", 32'(status), 32'(16'h2700 | 16'(base)));
                flag_we = 5'(we); flag_val = 5'(v);
                tick();
                chk("R3 flag enables", 32'(status[4:0]),
                    32'((base & ~5'(we)) | (5'(v) & 5'(we))));
                chk("R3 high byte kept", 32'(status[15:8]), 32'h27);
            end
        end

        // R7 precedence in supervisor mode
        word_we = 1; word_wdata = 16'h2705; ccr_we = 1; ccr_wdata = 8'h1F;
        flag_we = 5'h1F; flag_val = 5'h1A;
        tick();
        chk("R7 word over byte/flags", 32'(status), 32'h2705);
        ccr_we = 1; ccr_wdata = 8'h0A; flag_we = 5'h1F; flag_val = 5'h15;
        tick();
        chk("R7 byte over flags", 32'(status), 32'h270A);

        // R8 exception beats a same-cycle word write
        word_we = 1; word_wdata = 16'h0000; exc_entry = 1; flag_we = 5'h1F;
        tick();
        chk("R8 status kept", 32'(status), 32'h270A);
        chk("R8 saved", 32'(saved_status), 32'h270A);
        chk("R8 no fault", 32'(priv_fault), 0);

        // R5 / R6 / R2 / R8 sweep over word values
        for (int w = 0; w < 65536; w += 7) begin
            logic [15:0] exp;
            exp = 16'(w) & MASK;
            word_we = 1; word_wdata = 16'(w);
            tick();
            chk("R5 R2 word write", 32'(status), 32'(exp));
            chk("R6 no fault in supervisor", 32'(priv_fault), 0);
            cur = exp;
            if (!exp[13]) begin
                word_we = 1; word_wdata = ~16'(w); ccr_we = 1; flag_we = 5'h1F;
                flag_val = ~5'(w);
                tick();
                chk("R6 refused word", 32'(status), 32'(exp));
                chk("R6 fault pulse", 32'(priv_fault), 1);
                ccr_we = 1; ccr_wdata = ~8'(w);
                tick();
                chk("R6 fault one cycle", 32'(priv_fault), 0);
                cur = (exp & 16'hFF00) | 16'(~8'(w) & 8'h1F);
                chk("R4 user byte write", 32'(status), 32'(cur));
            end
            exc_entry = 1;
            tick();
            chk("R8 saved copy", 32'(saved_status), 32'(cur));
            chk("R8 supervisor set", 32'(status), 32'(cur | 16'h2000));
        end

        // R9 / R10 stack pointer selection
        word_we = 1; word_wdata = 16'h2700;
        tick();
        sp_we = 1; sp_wdata = 32'h0000_1234;
        tick();
        chk("R9 supervisor sp write", active_sp, 32'h0000_1234);
        word_we = 1; word_wdata = 16'h0000;
        tick();
        chk("R10 switch to user sp", active_sp, 32'h0);
        chk("R10 mode user", 32'(supervisor), 0);
        sp_we = 1; sp_wdata = 32'hABCD_0000;
        tick();
        chk("R9 user sp write", active_sp, 32'hABCD_0000);
        exc_entry = 1;
        tick();
        chk("R10 back to supervisor sp", active_sp, 32'h0000_1234);
        word_we = 1; word_wdata = 16'h0000;
        tick();
        chk("R9 user sp retained", active_sp, 32'hABCD_0000);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule